// File: doc/BRIEF.md
# Dual-Mode Display Identification Memory

This block is a 128-byte identification memory that a display presents to its host over a two-wire link. It works in two modes. After reset it is in a broadcast mode. No address is sent: each rising edge on the `vclk` strobe moves the data line to the next bit of the array, most significant bit first. After the last byte the stream wraps back to byte 0.

The first falling edge seen on `scl` moves the block into a bidirectional I2C slave mode. In that mode it answers device select bytes whose upper nibble is `1010`. It accepts a word address and performs single-byte writes and sequential reads. While the block is in slave mode, the `vclk` pin is the write permission input. A configuration pin `cfg_temp` decides whether slave mode is permanent until reset, or whether a `vclk` rising edge on an idle bus after a STOP sends the block back to broadcast mode.

All pins are sampled by the system clock through a two-stage synchroniser. The data line is open drain: `sda_oe` high means the block pulls the line low.

The slave state machine has the states IDLE, DEV (receive the device select byte), DEV_ACK, ADDR (receive the word address), ADDR_ACK, DATA (receive the data byte), DATA_ACK, HOLD (wait for the STOP), SEND (shift out a byte), MACK (sample the master acknowledge) and SKIP (stay silent until the next START or STOP). The transitions are as follows:
- A START from any state goes to DEV, and a STOP from any state goes to IDLE.
- After 8 bits, DEV goes to DEV_ACK on a matching select byte and to SKIP otherwise.
- DEV_ACK goes to SEND for a read and to ADDR for a write.
- ADDR goes to ADDR_ACK, then DATA, then DATA_ACK, then HOLD.
- SEND goes to MACK after 8 bits. MACK goes back to SEND when the master acknowledges, and to SKIP when it does not.

The mode latch has two states, broadcast and slave. A falling `scl` edge takes it from broadcast to slave. A `vclk` rising edge in temporary configuration, while the bus is idle after a STOP, takes it from slave back to broadcast.

Top module: `ddc_dual_eeprom`

## Requirements
- R1: While `rst_n` is low and right after it is released, `bidir_mode` is 0, the memory holds its initial contents, and the stream points at bit 7 of byte 0, so `sda_oe` equals the inverse of that bit.
- R2: In broadcast mode, each rising edge of `vclk` moves the stream to the next lower bit. After bit 0 it moves to bit 7 of the next byte, and byte 127 is followed by byte 0. `sda_oe` is the inverse of the selected bit and does not change without a `vclk` rising edge.
- R3: A falling edge on `scl` in broadcast mode sets `bidir_mode` to 1 and releases the data line (`sda_oe` = 0).
- R4: In slave mode the block pulls the data line low during the 9th clock only after a device select whose bits 7..4 are `1010`. Any other select byte is not acknowledged, and the block stays silent until the next START. The line is never pulled low while the slave is idle.
- R5: A write is a select byte with bit 0 = 0, then a word address, then one data byte, and each of the three is acknowledged. Bit 7 of the word address is ignored. On STOP the byte is stored when `vclk` is 1. The current address stays at the written word.
- R6: When `vclk` is 0 at the STOP, the write is not executed and the memory is unchanged.
- R7: A select byte with bit 0 = 1 returns the byte at the current address, MSB first, and then increments the address modulo 128. Reading continues while the master acknowledges. When the master does not acknowledge, the block releases the line.
- R8: With `cfg_temp` = 0, slave mode is kept until reset, whatever `vclk` does.
- R9: With `cfg_temp` = 1, a rising edge on `vclk` while the slave is idle after a STOP returns the block to broadcast mode, with the stream restarted at bit 7 of byte 0.
- R10: After reset, byte i holds ({i[6:0],1'b0}) XOR 8'hA5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all pins |
| rst_n | input | 1 | Active-low reset (stands in for power-on reset) |
| scl | input | 1 | Two-wire bus clock |
| sda_in | input | 1 | Level seen on the data line |
| vclk | input | 1 | Broadcast strobe; write permission in slave mode |
| cfg_temp | input | 1 | 1 = slave mode may revert to broadcast, 0 = locked |
| sda_oe | output | 1 | 1 = pull the data line low |
| bidir_mode | output | 1 | 1 = slave mode, 0 = broadcast mode |

## Verification
The assertions assume that the pins change slowly compared with `clk`, so that every pin edge reaches the synchroniser as a clean level that holds for several cycles. They also assume that the bus master moves the data line only while `scl` is low, except for START and STOP conditions. The bench holds every bus phase for six clock cycles and every `vclk` level for four. It releases its own data driver before each acknowledge and read phase, and it changes `vclk` only between transactions. In temporary configuration it changes `vclk` only in the one place where a return to broadcast mode is intended.

// File: rtl/ddc_pkg.sv
package ddc_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_HOLD,
        ST_SEND,
        ST_MACK,
        ST_SKIP
    } slv_state_t;

    typedef enum logic {
        MD_STREAM = 1'b0,
        MD_SLAVE  = 1'b1
    } mode_t;
endpackage

// File: rtl/ddc_edge.sv
module ddc_edge #(
    parameter int         N    = 3,
    parameter logic [N-1:0] IDLE = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw,
    output logic [N-1:0] lvl,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    for (genvar g = 0; g < N; g++) begin : g_pin
        logic s1, s2, s3;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1 <= IDLE[g];
                s2 <= IDLE[g];
                s3 <= IDLE[g];
            end else begin
                s1 <= raw[g];
                s2 <= s1;
                s3 <= s2;
            end
        end
        assign lvl[g]  = s2;
        assign rise[g] = s2 & ~s3;
        assign fall[g] = ~s2 & s3;
    end
endmodule

// File: rtl/ddc_stream.sv
module ddc_stream #(
    parameter int DW = 8,
    parameter int AW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    input  logic          restart,
    output logic [AW-1:0] addr,
    output logic [$clog2(DW)-1:0] bitsel
);
    localparam int BW = $clog2(DW);
    localparam logic [BW-1:0] TOP_BIT = BW'(DW - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr   <= '0;
            bitsel <= TOP_BIT;
        end else if (restart) begin
            addr   <= '0;
            bitsel <= TOP_BIT;
        end else if (adv) begin
            if (bitsel == '0) begin
                bitsel <= TOP_BIT;
                addr   <= addr + 1'b1;
            end else begin
                bitsel <= bitsel - 1'b1;
            end
        end
    end
endmodule

// File: rtl/ddc_mem.sv
module ddc_mem #(
    parameter int          DEPTH    = 128,
    parameter int          DW       = 8,
    parameter logic [DW-1:0] INIT_XOR = 8'hA5,
    localparam int         AW       = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [DW-1:0] rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [DW-1:0] rdata_b
);
    logic [DW-1:0] words [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                words[i] <= DW'(i << 1) ^ INIT_XOR;
            end
        end else if (we) begin
            words[waddr] <= wdata;
        end
    end

    assign rdata_a = words[raddr_a];
    assign rdata_b = words[raddr_b];
endmodule

// File: rtl/ddc_i2c_slave.sv
module ddc_i2c_slave
    import ddc_pkg::*;
#(
    parameter int         DW       = 8,
    parameter int         AW       = 7,
    parameter logic [3:0] DEV_CODE = 4'b1010
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          scl_lvl,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          sda_lvl,
    input  logic          sda_rise,
    input  logic          sda_fall,
    input  logic          wr_ok,
    input  logic [DW-1:0] rdata,
    output logic [AW-1:0] addr,
    output logic          mem_we,
    output logic [DW-1:0] wdata,
    output logic          drive_low,
    output logic          idle_after_stop
);
    localparam int CW = $clog2(DW + 1);
    localparam logic [CW-1:0] FULL = CW'(DW);
    localparam logic [CW-1:0] LAST = CW'(DW - 1);

    slv_state_t    state, nxt;
    logic [CW-1:0] cnt;
    logic [DW-1:0] shreg, tx_sh;
    logic          rw, pend, mack_ok, seen_stop;
    logic          start, stop;

    assign start = sda_fall & scl_lvl;
    assign stop  = sda_rise & scl_lvl;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        if (!en)        nxt = ST_IDLE;
        else if (start) nxt = ST_DEV;
        else if (stop)  nxt = ST_IDLE;
        else if (scl_fall) begin
            unique case (state)
                ST_DEV:      if (cnt == FULL)
                                 nxt = (shreg[DW-1 -: 4] == DEV_CODE) ? ST_DEV_ACK : ST_SKIP;
                ST_DEV_ACK:  nxt = rw ? ST_SEND : ST_ADDR;
                ST_ADDR:     if (cnt == FULL) nxt = ST_ADDR_ACK;
                ST_ADDR_ACK: nxt = ST_DATA;
                ST_DATA:     if (cnt == FULL) nxt = ST_DATA_ACK;
                ST_DATA_ACK: nxt = ST_HOLD;
                ST_SEND:     if (cnt == LAST) nxt = ST_MACK;
                ST_MACK:     nxt = mack_ok ? ST_SEND : ST_SKIP;
                default:     nxt = state;
            endcase
        end
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            shreg     <= '0;
            tx_sh     <= '0;
            rw        <= 1'b0;
            pend      <= 1'b0;
            mack_ok   <= 1'b0;
            seen_stop <= 1'b0;
            addr      <= '0;
            wdata     <= '0;
        end else if (!en || start) begin
            cnt       <= '0;
            pend      <= 1'b0;
            seen_stop <= 1'b0;
        end else if (stop) begin
            cnt       <= '0;
            pend      <= 1'b0;
            seen_stop <= 1'b1;
        end else if (scl_rise) begin
            if ((state inside {ST_DEV, ST_ADDR, ST_DATA}) && cnt != FULL) begin
                shreg <= {shreg[DW-2:0], sda_lvl};
                cnt   <= cnt + 1'b1;
            end
            if (state == ST_MACK) mack_ok <= ~sda_lvl;
        end else if (scl_fall) begin
            unique case (state)
                ST_DEV:     if (cnt == FULL) begin rw <= shreg[0]; cnt <= '0; end
                ST_DEV_ACK: if (rw) tx_sh <= rdata;
                ST_ADDR:    if (cnt == FULL) begin addr <= shreg[AW-1:0]; cnt <= '0; end
                ST_DATA:    if (cnt == FULL) begin wdata <= shreg; pend <= 1'b1; cnt <= '0; end
                ST_SEND: begin
                    if (cnt == LAST) begin
                        cnt  <= '0;
                        addr <= addr + 1'b1;
                    end else begin
                        tx_sh <= {tx_sh[DW-2:0], 1'b0};
                        cnt   <= cnt + 1'b1;
                    end
                end
                ST_MACK:    tx_sh <= rdata;
                default:    ;
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            ST_DEV_ACK, ST_ADDR_ACK, ST_DATA_ACK: drive_low = en;
            ST_SEND:                              drive_low = en & ~tx_sh[DW-1];
            default:                              drive_low = 1'b0;
        endcase
        mem_we          = en & stop & (state == ST_HOLD) & pend & wr_ok;
        idle_after_stop = (state == ST_IDLE) & seen_stop;
    end
endmodule

// File: rtl/ddc_dual_eeprom.sv
module ddc_dual_eeprom
    import ddc_pkg::*;
#(
    parameter int          DEPTH    = 128,
    parameter int          DW       = 8,
    parameter logic [3:0]  DEV_CODE = 4'b1010,
    parameter logic [DW-1:0] INIT_XOR = 8'hA5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    input  logic sda_in,
    input  logic vclk,
    input  logic cfg_temp,
    output logic sda_oe,
    output logic bidir_mode
);
    localparam int AW = $clog2(DEPTH);
    localparam int BW = $clog2(DW);

    logic [2:0] e_lvl, e_rise, e_fall;
    logic scl_lvl, scl_rise, scl_fall, sda_lvl, sda_rise, sda_fall;
    logic vclk_lvl, vclk_rise, unused_vclk_fall;
    logic slv_idle, slv_drive, mem_we, to_stream;
    logic [AW-1:0] s_addr, m_addr;
    logic [BW-1:0] s_bit;
    logic [DW-1:0] s_data, m_rdata, m_wdata;
    mode_t mode, mode_nxt;

    ddc_edge #(.N(3), .IDLE(3'b011)) u_edge (
        .clk(clk), .rst_n(rst_n), .raw({vclk, sda_in, scl}),
        .lvl(e_lvl), .rise(e_rise), .fall(e_fall)
    );

    assign scl_lvl  = e_lvl[0];
    assign scl_rise = e_rise[0];
    assign scl_fall = e_fall[0];
    assign sda_lvl  = e_lvl[1];
    assign sda_rise = e_rise[1];
    assign sda_fall = e_fall[1];
    assign vclk_lvl = e_lvl[2];
    assign vclk_rise = e_rise[2];
    assign unused_vclk_fall = e_fall[2];

    // mode latch: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode <= MD_STREAM;
        else        mode <= mode_nxt;
    end

    always_comb begin
        mode_nxt = mode;
        unique case (mode)
            MD_STREAM: if (scl_fall) mode_nxt = MD_SLAVE;
            MD_SLAVE:  if (cfg_temp && slv_idle && vclk_rise) mode_nxt = MD_STREAM;
            default:   mode_nxt = MD_STREAM;
        endcase
    end

    assign to_stream = (mode == MD_SLAVE) && (mode_nxt == MD_STREAM);

    ddc_stream #(.DW(DW), .AW(AW)) u_stream (
        .clk(clk), .rst_n(rst_n),
        .adv((mode == MD_STREAM) && vclk_rise),
        .restart(to_stream),
        .addr(s_addr), .bitsel(s_bit)
    );

    ddc_mem #(.DEPTH(DEPTH), .DW(DW), .INIT_XOR(INIT_XOR)) u_mem (
        .clk(clk), .rst_n(rst_n),
        .we(mem_we), .waddr(m_addr), .wdata(m_wdata),
        .raddr_a(s_addr), .rdata_a(s_data),
        .raddr_b(m_addr), .rdata_b(m_rdata)
    );

    ddc_i2c_slave #(.DW(DW), .AW(AW), .DEV_CODE(DEV_CODE)) u_slave (
        .clk(clk), .rst_n(rst_n), .en(mode == MD_SLAVE),
        .scl_lvl(scl_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .sda_lvl(sda_lvl), .sda_rise(sda_rise), .sda_fall(sda_fall),
        .wr_ok(vclk_lvl), .rdata(m_rdata),
        .addr(m_addr), .mem_we(mem_we), .wdata(m_wdata),
        .drive_low(slv_drive), .idle_after_stop(slv_idle)
    );

    // outputs
    always_comb begin
        bidir_mode = (mode == MD_SLAVE);
        sda_oe     = bidir_mode ? slv_drive : ~s_data[s_bit];
    end
endmodule

// File: rtl/ddc_dual_eeprom_chk.sv
module ddc_dual_eeprom_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_temp,
    input logic bidir_mode,
    input logic sda_oe,
    input logic scl_fall,
    input logic scl_lvl,
    input logic vclk_rise,
    input logic slv_idle
);
    AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_temp && bidir_mode) |=> bidir_mode); // R8

    AST_ENTER_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bidir_mode) |-> $past(scl_fall)); // R3

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (bidir_mode && slv_idle) |-> !sda_oe); // R4

    AST_PULL_ON_LOW_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (bidir_mode && $rose(sda_oe)) |-> !scl_lvl); // R4

    AST_STREAM_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (!bidir_mode && $past(!bidir_mode) && !$past(vclk_rise)) |-> $stable(sda_oe)); // R2
endmodule

bind ddc_dual_eeprom ddc_dual_eeprom_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_temp(cfg_temp), .bidir_mode(bidir_mode),
    .sda_oe(sda_oe), .scl_fall(scl_fall), .scl_lvl(scl_lvl),
    .vclk_rise(vclk_rise), .slv_idle(slv_idle)
);

// File: tb/sim_ddc_dual_eeprom.sv
module sim_ddc_dual_eeprom;
    localparam int DEPTH = 128;
    localparam int PH    = 6;

    logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, m_sda = 1'b1, vclk = 1'b0, cfg_temp = 1'b0;
    logic sda_oe, bidir_mode;
    logic sda_bus;
    assign sda_bus = m_sda & ~sda_oe;

    always #5 clk = ~clk;

    ddc_dual_eeprom u0 (
        .clk(clk), .rst_n(rst_n), .scl(scl), .sda_in(sda_bus), .vclk(vclk),
        .cfg_temp(cfg_temp), .sda_oe(sda_oe), .bidir_mode(bidir_mode)
    );

    int total = 0, bad = 0;
    bit finished = 0;
    logic [7:0] model [DEPTH];
    int ptr, s_addr, s_bit;

    function automatic logic [7:0] init_val(int i);
        logic [6:0] a = 7'(i);
        return {a, 1'b0} ^ 8'hA5;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(bit temp);
        rst_n = 0; scl = 1; m_sda = 1; vclk = 0; cfg_temp = temp;
        tick(4);
        for (int i = 0; i < DEPTH; i++) model[i] = init_val(i);
        ptr = 0; s_addr = 0; s_bit = 7;
        chk(bidir_mode == 0, "R1 mode in reset", bidir_mode, 0);
        rst_n = 1;
        tick(4);
        chk(bidir_mode == 0, "R1 mode after reset", bidir_mode, 0);
        chk(sda_oe == !model[0][7], "R1 R10 first bit", sda_oe, !model[0][7]);
    endtask

    task automatic stream_step(string req);
        vclk = 1; tick(4); vclk = 0; tick(4);
        if (s_bit == 0) begin s_bit = 7; s_addr = (s_addr + 1) % DEPTH; end
        else s_bit--;
        chk(sda_oe == !model[s_addr][s_bit], req, sda_oe, !model[s_addr][s_bit]);
    endtask

    task automatic enter_slave();
        scl = 0; tick(PH);
        chk(bidir_mode == 1, "R3 mode switch", bidir_mode, 1);
        chk(sda_oe == 0, "R3 line released", sda_oe, 0);
        scl = 1; tick(PH);
    endtask

    task automatic i2c_start();
        m_sda = 1; tick(PH); scl = 1; tick(PH);
        m_sda = 0; tick(PH); scl = 0; tick(PH);
    endtask

    task automatic i2c_stop();
        m_sda = 0; tick(PH); scl = 1; tick(PH); m_sda = 1; tick(PH);
    endtask

    task automatic send_byte(logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; tick(PH); scl = 1; tick(PH); scl = 0; tick(PH);
        end
        m_sda = 1; tick(PH); scl = 1; tick(PH);
        ack = !sda_bus;
        scl = 0; tick(PH);
    endtask

    task automatic recv_byte(bit give_ack, output logic [7:0] b);
        m_sda = 1;
        for (int i = 7; i >= 0; i--) begin
            scl = 1; tick(PH); b[i] = sda_bus; scl = 0; tick(PH);
        end
        m_sda = !give_ack; tick(PH); scl = 1; tick(PH); scl = 0; tick(PH);
        m_sda = 1; tick(PH);
    endtask

    task automatic wr_txn(logic [7:0] a, logic [7:0] d, bit we);
        bit ack;
        vclk = we; tick(4);
        i2c_start();
        send_byte(8'hA0, ack); chk(ack, "R4 R5 select ack", ack, 1);
        send_byte(a, ack);     chk(ack, "R5 address ack", ack, 1);
        send_byte(d, ack);     chk(ack, "R5 data ack", ack, 1);
        i2c_stop();
        ptr = a[6:0];
        if (we) model[a[6:0]] = d;
    endtask

    task automatic rd_txn(logic [7:0] a, int n);
        bit ack;
        logic [7:0] got;
        i2c_start();
        send_byte(8'hA0, ack); chk(ack, "R4 select ack", ack, 1);
        send_byte(a, ack);     chk(ack, "R5 address ack", ack, 1);
        ptr = a[6:0];
        i2c_start();
        send_byte(8'hA1, ack); chk(ack, "R7 read select ack", ack, 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(k < n - 1, got);
            chk(got == model[ptr], "R7 R5 R6 read data", got, model[ptr]);
            ptr = (ptr + 1) % DEPTH;
        end
        chk(sda_oe == 0, "R7 released after no-ack", sda_oe, 0);
        i2c_stop();
    endtask

    initial begin
        bit ack;
        void'($urandom(32'h5EED));
        // broadcast mode with wrap-around
        do_reset(1'b0);
        for (int i = 0; i < DEPTH * 8 + 12; i++) stream_step("R2 R10 stream bit");
        // no strobe: stream holds
        tick(40);
        chk(sda_oe == !model[s_addr][s_bit], "R2 hold without strobe", sda_oe, !model[s_addr][s_bit]);

        // locked slave mode
        enter_slave();
        rd_txn(8'd0, 3);
        rd_txn(8'd126, 4);            // R7 address wrap
        wr_txn(8'h85, 8'h3C, 1'b1);   // R5 bit 7 of address ignored
        rd_txn(8'h05, 1);
        wr_txn(8'h10, 8'hC3, 1'b0);   // R6 write blocked
        rd_txn(8'h10, 1);
        for (int it = 0; it < 14; it++) begin
            logic [7:0] a, d;
            bit we;
            a  = 8'($urandom);
            d  = 8'($urandom);
            we = 1'($urandom);
            wr_txn(a, d, we);
            rd_txn(a, 1 + int'($urandom % 3));
        end
        // wrong device codes
        for (int it = 0; it < 4; it++) begin
            logic [7:0] dv;
            dv = 8'($urandom);
            if (dv[7:4] == 4'b1010) dv[7:4] = 4'b0110;
            i2c_start();
            send_byte(dv, ack);    chk(!ack, "R4 foreign select ignored", ack, 0);
            send_byte(8'h00, ack); chk(!ack, "R4 silent until START", ack, 0);
            i2c_stop();
        end
        // locked: strobe does not leave slave mode
        vclk = 0; tick(4); vclk = 1; tick(4); vclk = 0; tick(4);
        chk(bidir_mode == 1, "R8 locked mode kept", bidir_mode, 1);
        rd_txn(8'h20, 2);

        // temporary configuration
        do_reset(1'b1);
        for (int i = 0; i < 5; i++) stream_step("R2 stream before switch");
        enter_slave();
        wr_txn(8'h00, 8'h5A, 1'b1);
        chk(bidir_mode == 1, "R9 still slave before strobe", bidir_mode, 1);
        vclk = 0; tick(4); vclk = 1; tick(4); vclk = 0; tick(4);
        s_addr = 0; s_bit = 7;
        chk(bidir_mode == 0, "R9 back to broadcast", bidir_mode, 0);
        chk(sda_oe == !model[0][7], "R9 stream restarts at byte 0", sda_oe, !model[0][7]);
        for (int i = 0; i < 12; i++) stream_step("R9 R5 stream after return");

        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        tick(190000);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule